// File: doc/BRIEF.md
# SMBus Host Block Data Buffer

This block is the 32-byte staging store that sits behind the block data port of an SMBus host controller. When buffered mode is switched on, a whole SMBus block transfer moves through it at once. Before a block write, software fills the store through the data port. After a block read, software empties it through the same port. The protocol engine fills the store on reads and reads from it on writes, through a port of its own.

The block also holds three host registers. The byte count of a block transfer lives in a separate length register, not in the store. One index is shared by host reads and host writes of the data port. Every access moves the index on by one. A read of the control register puts the index back to zero as a side effect, so software rewinds the store with a plain register read.

When buffered mode is off, or the current transfer is an I2C-style block transfer, the data port becomes a single-byte register, which suits byte-at-a-time transfers.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset the control, length and mode registers read 0, `buf_active` is 0 and `len_ok` is 0. Register select codes: 0 = control, 1 = length, 2 = block data, 3 = mode. Mode bit 0 enables buffered mode.
- R2: When `buf_active` is 0, every host block-data access uses slot 0 and leaves the host index unchanged. Every engine write also goes to slot 0.
- R3: A host read of the control register sets the host index to 0, and the next block-data access uses slot 0.
- R4: In buffered mode, each host block-data access advances the host index by one. A write stores the byte at the index. A read returns the byte held at the index.
- R5: The host index saturates at 31. Further accesses reuse slot 31 and do not wrap.
- R6: The length register is written and read by the host. The engine can load it, and an engine load wins over a host write in the same cycle. `len_ok` is 1 exactly when the length is between 1 and 32.
- R7: `eng_start` sets the engine fill pointer to 0, and a start in the same cycle as a write takes priority over advancing the pointer. Each `eng_wr` stores a byte at the fill pointer and then advances it, saturating at 31. When the engine and the host write the store in the same cycle, the engine byte is kept, but the host index still advances.
- R8: `eng_rdata` always shows the slot selected by `eng_raddr`.
- R9: `buf_active` is mode bit 0 AND NOT `xfer_i2c`. An I2C-style block transfer never uses buffered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_sel | input | 2 | Register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (has side effects) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| xfer_i2c | input | 1 | Current block transfer is I2C-style |
| buf_active | output | 1 | Buffered mode is in use |
| len_ok | output | 1 | Length register holds a valid count |
| eng_start | input | 1 | Engine restarts its fill pointer |
| eng_wr | input | 1 | Engine stores a received byte |
| eng_wdata | input | 8 | Byte received by the engine |
| eng_len_wr | input | 1 | Engine loads the length register |
| eng_len | input | 8 | Length value from the engine |
| eng_raddr | input | 5 | Engine read slot |
| eng_rdata | output | 8 | Byte at the engine read slot |

## Verification
The hardest case to reach is the saturated index. Reaching it takes more block-data accesses than the store has slots, all without a control read in between. The stimulus writes 33 bytes in a row, then reads 33 bytes back. This shows that slot 31 holds the last byte written and keeps returning it.

The collision between an engine write and a host write in the same cycle is also awkward to reach. The bench drives both strobes in one cycle, then checks the engine port and the host's next slot.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_BLK  = 2'd2,
        SEL_MODE = 2'd3
    } smbb_sel_e;

    localparam int MODE_BUF_BIT = 0;
endpackage

// File: rtl/smbb_ptr.sv
module smbb_ptr #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else if (step && (st_q.ptr != LAST)) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/smbb_store.sv
module smbb_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } store_st_t;

    store_st_t st_d, st_q;
    logic [DEPTH-1:0] hit;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        assign hit[s] = wr_en && (wr_idx == IDX_W'(s));
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < DEPTH; s++) begin
            if (hit[s]) st_d.mem[s] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_a = st_q.mem[rd_idx_a];
    assign rd_data_b = st_q.mem[rd_idx_b];
endmodule

// File: rtl/smbb_regs.sv
module smbb_regs
    import smbb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  smbb_sel_e         sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_len_wr,
    input  logic [DATA_W-1:0] eng_len,
    input  logic [DATA_W-1:0] blk_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] len,
    output logic              buf_en
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] len;
        logic              buf_en;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_wr) begin
            case (sel)
                SEL_CTRL: st_d.ctrl   = wdata;
                SEL_LEN:  st_d.len    = wdata;
                SEL_MODE: st_d.buf_en = wdata[MODE_BUF_BIT];
                default:  ;
            endcase
        end
        if (eng_len_wr) st_d.len = eng_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = st_q.ctrl;
            SEL_LEN:  rdata = st_q.len;
            SEL_BLK:  rdata = blk_rdata;
            default:  rdata = {{(DATA_W-1){1'b0}}, st_q.buf_en};
        endcase
    end

    assign len    = st_q.len;
    assign buf_en = st_q.buf_en;
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf
    import smbb_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              xfer_i2c,
    output logic              buf_active,
    output logic              len_ok,
    input  logic              eng_start,
    input  logic              eng_wr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_len_wr,
    input  logic [DATA_W-1:0] eng_len,
    input  logic [IDX_W-1:0]  eng_raddr,
    output logic [DATA_W-1:0] eng_rdata
);
    smbb_sel_e         sel;
    logic              buf_en;
    logic              ctrl_rd;
    logic              blk_acc;
    logic              blk_wr;
    logic [IDX_W-1:0]  host_idx;
    logic [IDX_W-1:0]  fill_ptr;
    logic [IDX_W-1:0]  host_slot;
    logic [IDX_W-1:0]  eng_slot;
    logic              st_wr_en;
    logic [IDX_W-1:0]  st_wr_idx;
    logic [DATA_W-1:0] st_wr_data;
    logic [DATA_W-1:0] blk_rdata;
    logic [DATA_W-1:0] len_q;

    assign sel        = smbb_sel_e'(host_sel);
    assign buf_active = buf_en && !xfer_i2c;
    assign ctrl_rd    = host_rd && (sel == SEL_CTRL);
    assign blk_acc    = (host_rd || host_wr) && (sel == SEL_BLK);
    assign blk_wr     = host_wr && (sel == SEL_BLK);

    smbb_ptr #(.DEPTH(DEPTH)) u_host_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_rd),
        .step  (blk_acc && buf_active),
        .ptr   (host_idx)
    );

    smbb_ptr #(.DEPTH(DEPTH)) u_fill_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (eng_start),
        .step  (eng_wr && buf_active),
        .ptr   (fill_ptr)
    );

    assign host_slot = buf_active ? host_idx : '0;
    assign eng_slot  = buf_active ? fill_ptr : '0;

    always_comb begin
        st_wr_en   = eng_wr || blk_wr;
        st_wr_idx  = host_slot;
        st_wr_data = host_wdata;
        if (eng_wr) begin
            st_wr_idx  = eng_slot;
            st_wr_data = eng_wdata;
        end
    end

    smbb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_wr_en),
        .wr_idx    (st_wr_idx),
        .wr_data   (st_wr_data),
        .rd_idx_a  (host_slot),
        .rd_data_a (blk_rdata),
        .rd_idx_b  (eng_raddr),
        .rd_data_b (eng_rdata)
    );

    smbb_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .sel        (sel),
        .wdata      (host_wdata),
        .eng_len_wr (eng_len_wr),
        .eng_len    (eng_len),
        .blk_rdata  (blk_rdata),
        .rdata      (host_rdata),
        .len        (len_q),
        .buf_en     (buf_en)
    );

    assign len_ok = (len_q != '0) && (len_q <= DATA_W'(DEPTH));
endmodule

// File: rtl/smbus_blkbuf_checker.sv
module smbus_blkbuf_checker #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_rd,
    input logic             blk_acc,
    input logic             buf_active,
    input logic [IDX_W-1:0] host_idx,
    input logic             eng_start,
    input logic [IDX_W-1:0] fill_ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    assert_idx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> (host_idx == '0));

    assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_acc && buf_active && host_idx != LAST) |=> (host_idx == $past(host_idx) + 1'b1));

    assert_idx_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_acc && buf_active && host_idx == LAST) |=> (host_idx == LAST));

    assert_idx_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_acc && !buf_active) |=> $stable(host_idx));

    assert_fill_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> (fill_ptr == '0));
endmodule

bind smbus_blkbuf smbus_blkbuf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_rd    (ctrl_rd),
    .blk_acc    (blk_acc),
    .buf_active (buf_active),
    .host_idx   (host_idx),
    .eng_start  (eng_start),
    .fill_ptr   (fill_ptr)
);

// File: tb/smbus_blkbuf_test.sv
module smbus_blkbuf_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [1:0] S_CTRL = 2'd0, S_LEN = 2'd1, S_BLK = 2'd2, S_MODE = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       xfer_i2c = 1'b0;
    logic       buf_active, len_ok;
    logic       eng_start = 1'b0, eng_wr = 1'b0, eng_len_wr = 1'b0;
    logic [7:0] eng_wdata = '0, eng_len = '0;
    logic [4:0] eng_raddr = '0;
    logic [7:0] eng_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_blkbuf uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_i2c(xfer_i2c), .buf_active(buf_active), .len_ok(len_ok),
        .eng_start(eng_start), .eng_wr(eng_wr), .eng_wdata(eng_wdata),
        .eng_len_wr(eng_len_wr), .eng_len(eng_len), .eng_raddr(eng_raddr),
        .eng_rdata(eng_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rewind();
        logic [7:0] tmp;
        hr(S_CTRL, tmp);
    endtask

    task automatic ew(input logic [7:0] d);
        @(negedge clk);
        eng_wr = 1'b1; eng_wdata = d;
        @(negedge clk);
        eng_wr = 1'b0;
    endtask

    task automatic estart();
        @(negedge clk);
        eng_start = 1'b1;
        @(negedge clk);
        eng_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        hr(S_CTRL, d); check("R1 ctrl", d, 0);
        hr(S_LEN, d);  check("R1 len", d, 0);
        hr(S_MODE, d); check("R1 mode", d, 0);
        check("R1 buf_active", buf_active, 0);
        check("R1 len_ok", len_ok, 0);
    endtask

    task automatic t_fill_drain();
        logic [7:0] d;
        hw(S_MODE, 8'h01);
        check("R9 buf_active on", buf_active, 1);
        rewind();
        for (int i = 0; i < 5; i++) hw(S_BLK, 8'hA0 + 8'(i));
        rewind();
        for (int i = 0; i < 5; i++) begin
            hr(S_BLK, d); check("R4 drain", d, 'hA0 + i);
        end
    endtask

    task automatic t_ctrl_reset();
        logic [7:0] d;
        rewind();
        hw(S_BLK, 8'hB0); hw(S_BLK, 8'hB1); hw(S_BLK, 8'hB2);
        rewind();
        hr(S_BLK, d); check("R3 first", d, 'hB0);
        hr(S_BLK, d); check("R4 second", d, 'hB1);
        rewind();
        hr(S_BLK, d); check("R3 rewind mid", d, 'hB0);
    endtask

    task automatic t_saturate();
        logic [7:0] d;
        rewind();
        for (int i = 0; i < 33; i++) hw(S_BLK, 8'(i + 1));
        rewind();
        for (int i = 0; i < 31; i++) begin
            hr(S_BLK, d); check("R5 low slots", d, i + 1);
        end
        hr(S_BLK, d); check("R5 slot31 last write", d, 'h21);
        hr(S_BLK, d); check("R5 no wrap", d, 'h21);
    endtask

    task automatic t_single();
        logic [7:0] d;
        rewind();
        hw(S_MODE, 8'h00);
        check("R2 buf_active off", buf_active, 0);
        hw(S_BLK, 8'h5A); hw(S_BLK, 8'h6B);
        hr(S_BLK, d); check("R2 slot0", d, 'h6B);
        hr(S_BLK, d); check("R2 slot0 again", d, 'h6B);
        hw(S_MODE, 8'h01);
        hr(S_BLK, d); check("R2 index unmoved", d, 'h6B);
        hr(S_BLK, d); check("R2 slot1 untouched", d, 'h02);
    endtask

    task automatic t_i2c();
        logic [7:0] d;
        rewind();
        rewind();
        @(negedge clk) xfer_i2c = 1'b1;
        #1 check("R9 i2c disables buffer", buf_active, 0);
        hw(S_BLK, 8'h77);
        @(negedge clk) xfer_i2c = 1'b0;
        rewind();
        hr(S_BLK, d); check("R9 wrote slot0", d, 'h77);
        hr(S_BLK, d); check("R9 slot1 kept", d, 'h02);
    endtask

    task automatic t_engine();
        logic [7:0] d;
        estart();
        for (int i = 0; i < 4; i++) ew(8'hC0 + 8'(i));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) eng_raddr = 5'(i);
            #1 check("R8 engine port", eng_rdata, 'hC0 + i);
        end
        rewind();
        for (int i = 0; i < 4; i++) begin
            hr(S_BLK, d); check("R7 engine fill order", d, 'hC0 + i);
        end
    endtask

    task automatic t_collide();
        logic [7:0] d;
        estart();
        rewind();
        @(negedge clk);
        host_sel = S_BLK; host_wdata = 8'h11; host_wr = 1'b1;
        eng_wr = 1'b1; eng_wdata = 8'hE0;
        @(negedge clk);
        host_wr = 1'b0; eng_wr = 1'b0; eng_raddr = 5'd0;
        #1 check("R7 engine wins", eng_rdata, 'hE0);
        hr(S_BLK, d); check("R7 host index advanced", d, 'hC1);
    endtask

    task automatic t_length();
        logic [7:0] d;
        hw(S_LEN, 8'd5);
        hr(S_LEN, d); check("R6 len readback", d, 5);
        check("R6 len 5 ok", len_ok, 1);
        hw(S_LEN, 8'd0);  check("R6 len 0 bad", len_ok, 0);
        hw(S_LEN, 8'd32); check("R6 len 32 ok", len_ok, 1);
        hw(S_LEN, 8'd33); check("R6 len 33 bad", len_ok, 0);
        hw(S_LEN, 8'd1);  check("R6 len 1 ok", len_ok, 1);
        @(negedge clk);
        host_sel = S_LEN; host_wdata = 8'd9; host_wr = 1'b1;
        eng_len = 8'd7; eng_len_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; eng_len_wr = 1'b0;
        hr(S_LEN, d); check("R6 engine load wins", d, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_drain();
        t_ctrl_reset();
        t_saturate();
        t_single();
        t_i2c();
        t_engine();
        t_collide();
        t_length();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule